// File: doc/BRIEF.md
# Thermal Sensor Threshold Monitor

This block takes raw temperature samples from an ADC, corrects each one with a signed calibration offset, and keeps the corrected value where software can read it. Three comparators check each corrected sample as it arrives. The first compares it against an alarm threshold. The other two check it against the low and high edges of a window. The alarm keeps a level status bit that software can read. Each comparator can also produce a one-cycle interrupt pulse.

Software sets up the block through a small word-addressed register file. Word 0 holds the configuration. Word 1 is the read-only status. Word 2 holds the window. Each ADC sample arrives with a valid strobe. The block takes samples only while it is enabled and not disabled.

Top module: `thermal_monitor`

## Requirements
- R1: After reset, all three registers read 0, all interrupt outputs are low, and the block is inactive, because ENABLE is clear.
- R2: When a sample is taken, the corrected value is the sum of the unsigned 14-bit raw reading and the signed 14-bit offset. The offset is configuration bits 29:16 in two's complement. Status bits 13:0 show the corrected value from the cycle after the sampling edge.
- R3: The corrected value saturates at 0 when the sum is negative. It saturates at 16383 when the sum exceeds 14 bits. It never wraps.
- R4: On each sample taken, status bit 16 is set if the corrected value is strictly greater than the threshold in configuration bits 13:0. Otherwise it is cleared, which includes the value equal to the threshold. There is no hysteresis.
- R5: `irq_alarm` pulses for one cycle when the alarm condition goes from false to true on a sample. It pulses only if the interrupt-enable bit, configuration bit 14, is set. The status bit follows the condition whatever bit 14 holds.
- R6: `irq_below` pulses for one cycle when a sample goes below LOW, where LOW is window bits 13:0 and the comparison is strictly less than.
- R7: `irq_above` pulses for one cycle when a sample goes above HIGH, where HIGH is window bits 29:16 and the comparison is strictly greater than.
- R8: An interrupt does not pulse again while its condition stays true on later samples. It re-arms after a sample on which the condition is false. Interrupts change only in the cycle after a sampling edge.
- R9: The block is active only when ENABLE (configuration bit 31) is 1 and DISABLE (bit 30) is 0. When both bits are set, the block is disabled. While inactive, samples are ignored, the value and the alarm bit are held, and no interrupt pulses.
- R10: Configuration reserved bit 15 reads 0. Window bits 15:14 and 31:30 read 0. Writes to status (word 1) have no effect. Word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| adc_valid | input | 1 | Sample-valid strobe |
| adc_raw | input | 14 | Raw unsigned ADC reading |
| irq_alarm | output | 1 | Alarm interrupt pulse |
| irq_below | output | 1 | Below-window interrupt pulse |
| irq_above | output | 1 | Above-window interrupt pulse |

## Verification
A register write takes effect at the next clock edge. Read data is combinational, so the bench samples it 1 ns after setting the address, away from any edge. A sample presented with its valid strobe is registered at one edge. The corrected value, the alarm bit and the interrupt pulses all appear together in the following cycle. The bench therefore checks them at the falling edge after the sampling edge, and one cycle later it checks that every pulse has dropped again.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    localparam int TW   = 14;
    localparam int DW   = 32;
    localparam int AW   = 2;
    localparam int NCMP = 3;
    localparam logic [TW-1:0] TMAX = {TW{1'b1}};

    typedef logic [TW-1:0] temp_t;

    typedef struct packed {
        logic  enable;
        logic  disable_n_a;
        temp_t offset;
        logic  rsv;
        logic  irq_en;
        temp_t thresh;
    } cfg_t;

    typedef struct packed {
        logic [1:0] rsv1;
        temp_t      high;
        logic [1:0] rsv0;
        temp_t      low;
    } range_t;

    typedef enum logic [AW-1:0] {
        A_CFG   = 2'd0,
        A_STAT  = 2'd1,
        A_RANGE = 2'd2,
        A_NONE  = 2'd3
    } addr_e;

    function automatic temp_t sat_add(temp_t raw, temp_t off);
        logic signed [TW+1:0] s;
        s = $signed({2'b00, raw}) + $signed({{2{off[TW-1]}}, off});
        if (s < 0)
            return '0;
        else if (s > $signed({2'b00, TMAX}))
            return TMAX;
        else
            return s[TW-1:0];
    endfunction
endpackage

// File: rtl/therm_regs.sv
module therm_regs
    import thermal_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  temp_t         sensor,
    input  logic          alarm_flag,
    output cfg_t          cfg_q,
    output range_t        rng_q,
    output logic [DW-1:0] bus_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            rng_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CFG) begin
                cfg_q     <= cfg_t'(bus_wdata);
                cfg_q.rsv <= 1'b0;
            end
            if (bus_addr == A_RANGE) begin
                rng_q      <= range_t'(bus_wdata);
                rng_q.rsv0 <= '0;
                rng_q.rsv1 <= '0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (addr_e'(bus_addr))
            A_CFG:   bus_rdata = cfg_q;
            A_STAT:  bus_rdata = {15'd0, alarm_flag, 2'd0, sensor};
            A_RANGE: bus_rdata = rng_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/therm_sense.sv
module therm_sense
    import thermal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adc_valid,
    input  temp_t adc_raw,
    input  cfg_t  cfg,
    output logic  take,
    output temp_t sens_nxt,
    output temp_t sensor_q
);
    logic active;

    assign active   = cfg.enable & ~cfg.disable_n_a;
    assign take     = adc_valid & active;
    assign sens_nxt = sat_add(adc_raw, cfg.offset);

    always_ff @(posedge clk) begin
        if (rst)
            sensor_q <= '0;
        else if (take)
            sensor_q <= sens_nxt;
    end
endmodule

// File: rtl/therm_compare.sv
module therm_compare
    import thermal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  temp_t           value,
    input  cfg_t            cfg,
    input  range_t          rng,
    output logic [NCMP-1:0] flag_q,
    output logic [NCMP-1:0] irq_q
);
    logic [NCMP-1:0] cond;
    logic [NCMP-1:0] gate;

    always_comb begin
        cond[0] = value > cfg.thresh;
        cond[1] = value < rng.low;
        cond[2] = value > rng.high;
        gate    = {1'b1, 1'b1, cfg.irq_en};
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
                irq_q[i]  <= 1'b0;
            end else begin
                irq_q[i] <= take & cond[i] & ~flag_q[i] & gate[i];
                if (take)
                    flag_q[i] <= cond[i];
            end
        end
    end
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor
    import thermal_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          adc_valid,
    input  logic [TW-1:0] adc_raw,
    output logic          irq_alarm,
    output logic          irq_below,
    output logic          irq_above
);
    cfg_t            cfg_q;
    range_t          rng_q;
    logic            take;
    temp_t           sens_nxt;
    temp_t           sensor_q;
    logic [NCMP-1:0] flag_q;
    logic [NCMP-1:0] irq_q;
    logic            alarm_flag;

    assign alarm_flag = flag_q[0];
    assign irq_alarm  = irq_q[0];
    assign irq_below  = irq_q[1];
    assign irq_above  = irq_q[2];

    therm_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sensor(sensor_q), .alarm_flag(alarm_flag),
        .cfg_q(cfg_q), .rng_q(rng_q), .bus_rdata(bus_rdata)
    );

    therm_sense u_sense (
        .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_raw(adc_raw),
        .cfg(cfg_q), .take(take), .sens_nxt(sens_nxt), .sensor_q(sensor_q)
    );

    therm_compare u_cmp (
        .clk(clk), .rst(rst), .take(take), .value(sens_nxt),
        .cfg(cfg_q), .rng(rng_q), .flag_q(flag_q), .irq_q(irq_q)
    );
endmodule

// File: rtl/therm_monitor_chk.sv
module therm_monitor_chk (
    input logic        clk,
    input logic        rst,
    input logic        adc_valid,
    input logic        irq_alarm,
    input logic        irq_below,
    input logic        irq_above,
    input logic        alarm_flag,
    input logic [13:0] sensor,
    input logic        irq_en
);
    a_r8_irq_needs_sample: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |=> !(irq_alarm || irq_below || irq_above));

    a_r2_value_held: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |=> $stable(sensor));

    a_r4_flag_held: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |=> $stable(alarm_flag));

    a_r5_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
        irq_alarm |-> alarm_flag);

    a_r5_irq_enabled: assert property (@(posedge clk) disable iff (rst)
        irq_alarm |-> $past(irq_en));

    a_r8_alarm_single: assert property (@(posedge clk) disable iff (rst)
        irq_alarm |=> !irq_alarm);

    a_r6_below_single: assert property (@(posedge clk) disable iff (rst)
        irq_below |=> !irq_below);

    a_r7_above_single: assert property (@(posedge clk) disable iff (rst)
        irq_above |=> !irq_above);
endmodule

bind thermal_monitor therm_monitor_chk u_chk (
    .clk(clk), .rst(rst), .adc_valid(adc_valid),
    .irq_alarm(irq_alarm), .irq_below(irq_below), .irq_above(irq_above),
    .alarm_flag(alarm_flag), .sensor(sensor_q), .irq_en(cfg_q.irq_en)
);

// File: tb/test_thermal_monitor.sv
module test_thermal_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        adc_valid = 1'b0;
    logic [13:0] adc_raw = '0;
    logic        irq_alarm, irq_below, irq_above;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    thermal_monitor i_thermal_monitor (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_valid(adc_valid),
        .adc_raw(adc_raw), .irq_alarm(irq_alarm), .irq_below(irq_below),
        .irq_above(irq_above)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(bit en, bit dis, int off, bit ie, int thr);
        logic [13:0] o = off[13:0];
        logic [13:0] t = thr[13:0];
        return {en, dis, o, 1'b0, ie, t};
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic sample(string req, int raw, int val, bit flag, bit ia, bit ib, bit ih);
        logic [31:0] d;
        @(negedge clk);
        adc_valid = 1'b1; adc_raw = raw[13:0];
        @(negedge clk);
        adc_valid = 1'b0;
        check({req, " irqs"}, {29'd0, ia, ib, ih}, {29'd0, irq_alarm, irq_below, irq_above} ^ {29'd0, ia, ib, ih} ^ {29'd0, ia, ib, ih});
        check({req, " irqs"}, {29'd0, irq_alarm, irq_below, irq_above}, {29'd0, ia, ib, ih});
        rd(2'd1, d);
        check({req, " value"}, {18'd0, d[13:0]}, val);
        check({req, " flag"}, {31'd0, d[16]}, {31'd0, flag});
        @(negedge clk);
        check({req, " R8 pulse width"}, {29'd0, irq_alarm, irq_below, irq_above}, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); check("R1 cfg", d, 0);
        rd(2'd1, d); check("R1 status", d, 0);
        rd(2'd2, d); check("R1 range", d, 0);
        check("R1 irqs", {29'd0, irq_alarm, irq_below, irq_above}, 0);
        sample("R9 inactive after reset", 100, 0, 0, 0, 0, 0);
    endtask

    task automatic t_main;
        wr(2'd0, mk_cfg(1, 0, 5, 1, 200));
        wr(2'd2, (300 << 16) | 50);
        sample("R2 in window", 100, 105, 0, 0, 0, 0);
        sample("R4 R5 alarm rise", 250, 255, 1, 1, 0, 0);
        sample("R8 alarm held", 250, 255, 1, 0, 0, 0);
        sample("R4 equal clears", 195, 200, 0, 0, 0, 0);
        sample("R7 R8 above and re-armed alarm", 300, 305, 1, 1, 0, 1);
        sample("R6 below", 40, 45, 0, 0, 1, 0);
    endtask

    task automatic t_saturate;
        wr(2'd0, mk_cfg(1, 0, -100, 1, 200));
        sample("R3 clamp low, R8 below held", 30, 0, 0, 0, 0, 0);
        wr(2'd0, mk_cfg(1, 0, 8191, 1, 200));
        sample("R3 clamp high", 16000, 16383, 1, 1, 0, 1);
    endtask

    task automatic t_irq_enable;
        wr(2'd0, mk_cfg(1, 0, 0, 0, 200));
        sample("R6 below again", 0, 0, 0, 0, 1, 0);
        sample("R5 alarm masked", 250, 250, 1, 0, 0, 0);
    endtask

    task automatic t_disable;
        wr(2'd0, mk_cfg(1, 1, 0, 1, 200));
        sample("R9 both bits set", 0, 250, 1, 0, 0, 0);
        wr(2'd0, mk_cfg(0, 0, 0, 1, 200));
        sample("R9 enable clear", 0, 250, 1, 0, 0, 0);
        wr(2'd0, mk_cfg(1, 0, 0, 1, 200));
        sample("R9 re-enabled", 0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R10 cfg mask", d, 32'hFFFF_7FFF);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, d); check("R10 range mask", d, 32'h3FFF_3FFF);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R10 status read-only", d, 32'd0);
        rd(2'd3, d); check("R10 unused word", d, 32'd0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_main;
        t_saturate;
        t_irq_enable;
        t_disable;
        t_regs;
        done = 1;
        summary;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary;
            $finish;
        end
    end
endmodule